// File: doc/BRIEF.md
# Microcode Engine Arithmetic and Logic Unit

This block is the data path of a small 16-bit microcode engine of the kind that runs inside a wireless MAC controller. Each cycle it receives two operands, a 4-bit operation code and a qualifier that asks for the carry flag to be written. The main result is combinational. The carry flag and the low half of the last product sit in registers inside the block and change on the clock edge where the execute enable is high.

Add and subtract each come in four forms. One choice is whether the stored carry is consumed as carry-in. The other is whether the carry-out is written back. The operation code makes the first choice and the set-carry qualifier makes the second. Multiply returns the upper half of the unsigned product as the main result and keeps the lower half in a side register. A register copy needs no path of its own: it is an OR with a zero second operand.

Top module: `ucode_alu`

## Requirements
- R1: After reset the carry flag reads 0 and the product-low register reads 0.
- R2: Operation codes are: 0 add, 1 add with carry-in, 2 subtract, 3 subtract with carry-in, 4 OR, 5 AND, 6 XOR, 7 clear-bits, 8 logical right shift, 9 left shift, 10 arithmetic right shift, 11 rotate left, 12 rotate right, 13 multiply. Codes 14 and 15 give a result of 0 and change no state.
- R3: Code 0 gives (a+b) mod 2^16. Code 1 gives (a+b+carry) mod 2^16.
- R4: Code 2 gives (a-b) mod 2^16. Code 3 gives (a-b-1+carry) mod 2^16.
- R5: When the execute enable and set_carry are both high on codes 0 to 3, the carry flag takes the carry-out of the 17-bit sum. For add this is the unsigned overflow. For subtract it means no borrow; with code 2 it equals a >= b, unsigned.
- R6: The carry flag keeps its value when the execute enable is low, when set_carry is low, or when the code is 4 or above.
- R7: Code 4 gives a|b, code 5 gives a&b, code 6 gives a^b and code 7 gives a & ~b. Code 4 with b = 0 returns a unchanged, which serves as a copy.
- R8: Shift codes 8, 9 and 10 use only b[3:0] as the shift amount and ignore b[15:4]. The arithmetic right shift fills with a[15].
- R9: Rotate codes 11 and 12 turn a by b[3:0] places. Bits leaving one end enter at the other.
- R10: Code 13 gives bits [31:16] of the unsigned 32-bit product a*b as the main result.
- R11: On an enabled code 13 the product-low register takes bits [15:0] of a*b. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| exec_en | input | 1 | Execute enable; gates every register update |
| opcode | input | 4 | Operation code (see R2) |
| set_carry | input | 1 | Write the carry-out of add/subtract into the carry flag |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second operand, or shift/rotate amount in bits [3:0] |
| result | output | 16 | Combinational main result |
| mul_lo | output | 16 | Low half of the most recent enabled product |
| carry | output | 1 | Carry flag |

## Verification
The only internal state is the carry flag and the product-low register. A wrong carry shows on the carry port one edge after the enabled add or subtract that wrote it. It also shows in the main result of the next carry-consuming add or subtract. For that reason the bench loads a known carry before every vector and checks the flag after every edge, including edges where the enable, the qualifier or the operation code should have left it alone. A wrong product-low value shows on mul_lo one edge after an enabled multiply, and a missing hold shows after any other operation.

// File: rtl/ucode_alu_pkg.sv
package ucode_alu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_OR   = 4'd4,
    OP_AND  = 4'd5,
    OP_XOR  = 4'd6,
    OP_CLR  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SLL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_MUL  = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/ucode_alu_addsub.sv
module ucode_alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
  end
endmodule

// File: rtl/ucode_alu_shift.sv
module ucode_alu_shift #(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  input  logic           rotate,
  input  logic           arith,
  output logic [W-1:0]   left_out,
  output logic [W-1:0]   right_out
);
  logic [W-1:0] lst [SHW+1];
  logic [W-1:0] rst [SHW+1];
  logic         fill;

  assign fill   = arith & a[W-1];
  assign lst[0] = a;
  assign rst[0] = a;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] l_mv;
    logic [W-1:0] r_mv;
    always_comb begin
      if (rotate) begin
        l_mv = {lst[k][W-1-S:0], lst[k][W-1:W-S]};
        r_mv = {rst[k][S-1:0], rst[k][W-1:S]};
      end else begin
        l_mv = {lst[k][W-1-S:0], {S{1'b0}}};
        r_mv = {{S{fill}}, rst[k][W-1:S]};
      end
    end
    assign lst[k+1] = amt[k] ? l_mv : lst[k];
    assign rst[k+1] = amt[k] ? r_mv : rst[k];
  end

  assign left_out  = lst[SHW];
  assign right_out = rst[SHW];
endmodule

// File: rtl/ucode_alu_logic.sv
module ucode_alu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a | b;
      2'd1:    y = a & b;
      2'd2:    y = a ^ b;
      default: y = a & ~b;
    endcase
  end
endmodule

// File: rtl/ucode_alu_mul.sv
module ucode_alu_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic [2*W-1:0] prod;
  assign prod = a * b;
  assign hi   = prod[2*W-1:W];
  assign lo   = prod[W-1:0];
endmodule

// File: rtl/ucode_alu.sv
module ucode_alu
  import ucode_alu_pkg::*;
#(
  parameter int W = 16,
  localparam int SHW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [OPW-1:0]    opcode,
  input  logic              set_carry,
  input  logic [W-1:0]      src_a,
  input  logic [W-1:0]      src_b,
  output logic [W-1:0]      result,
  output logic [W-1:0]      mul_lo,
  output logic              carry
);
  alu_op_e op;
  assign op = alu_op_e'(opcode);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic carry_q, carry_d, carry_we;
  logic [W-1:0] mlo_q, mlo_d;
  logic         mlo_we;

  // add / subtract
  logic         is_sub, uses_cin, is_arith, as_cin, as_cout;
  logic [W-1:0] as_sum;
  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SUBC);
    uses_cin = (op == OP_ADDC) || (op == OP_SUBC);
    is_arith = (op == OP_ADD) || (op == OP_ADDC) || is_sub;
    as_cin   = uses_cin ? carry_q : is_sub;
  end

  ucode_alu_addsub #(.W(W)) u_addsub (
    .a(src_a), .b(src_b), .sub(is_sub), .cin(as_cin),
    .sum(as_sum), .cout(as_cout)
  );

  // logic unit
  logic [W-1:0] lg_y;
  ucode_alu_logic #(.W(W)) u_logic (
    .a(src_a), .b(src_b), .sel(opcode[1:0]), .y(lg_y)
  );

  // shifter / rotator
  logic [W-1:0] sh_l, sh_r;
  logic         sh_rot, sh_arith;
  assign sh_rot   = (op == OP_ROL) || (op == OP_ROR);
  assign sh_arith = (op == OP_SRA);
  ucode_alu_shift #(.W(W)) u_shift (
    .a(src_a), .amt(src_b[SHW-1:0]), .rotate(sh_rot), .arith(sh_arith),
    .left_out(sh_l), .right_out(sh_r)
  );

  // multiplier
  logic [W-1:0] mu_hi, mu_lo;
  ucode_alu_mul #(.W(W)) u_mul (
    .a(src_a), .b(src_b), .hi(mu_hi), .lo(mu_lo)
  );

  // result select
  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: result = as_sum;
      OP_OR, OP_AND, OP_XOR, OP_CLR:    result = lg_y;
      OP_SLL, OP_ROL:                   result = sh_l;
      OP_SRL, OP_SRA, OP_ROR:           result = sh_r;
      OP_MUL:                           result = mu_hi;
      default:                          result = '0;
    endcase
  end

  // next state
  always_comb begin
    carry_we = exec_en & set_carry & is_arith;
    carry_d  = carry_we ? as_cout : carry_q;
    mlo_we   = exec_en & (op == OP_MUL);
    mlo_d    = mlo_we ? mu_lo : mlo_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      carry_q <= 1'b0;
      mlo_q   <= '0;
    end else begin
      carry_q <= carry_d;
      mlo_q   <= mlo_d;
    end
  end

  assign carry  = carry_q;
  assign mul_lo = mlo_q;
endmodule

// File: rtl/ucode_alu_chk.sv
module ucode_alu_chk
  import ucode_alu_pkg::*;
#(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           exec_en,
  input logic [OPW-1:0] opcode,
  input logic           set_carry,
  input logic [W-1:0]   src_a,
  input logic [W-1:0]   src_b,
  input logic [W-1:0]   result,
  input logic [W-1:0]   mul_lo,
  input logic           carry
);
  logic [2*W-1:0] ref_prod;
  logic [W:0]     ref_add;
  assign ref_prod = {{W{1'b0}}, src_a} * {{W{1'b0}}, src_b};
  assign ref_add  = {1'b0, src_a} + {1'b0, src_b};

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en || !set_carry || opcode > OP_SUBC) |=> $stable(carry)); // R6
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && set_carry && opcode == OP_ADD) |=> carry == $past(ref_add[W])); // R5
  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && set_carry && opcode == OP_SUB) |=> carry == $past(src_a >= src_b)); // R5
  AST_MUL_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == OP_MUL) |=> mul_lo == $past(ref_prod[W-1:0])); // R11
  AST_MUL_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && opcode == OP_MUL) |=> $stable(mul_lo)); // R11
  AST_MUL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_MUL) |-> result == ref_prod[2*W-1:W]); // R10
  AST_COPY_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_OR && src_b == '0) |-> result == src_a); // R7
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode >= OP_RS14) |-> result == '0); // R2
endmodule

bind ucode_alu ucode_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .exec_en(exec_en), .opcode(opcode),
  .set_carry(set_carry), .src_a(src_a), .src_b(src_b), .result(result),
  .mul_lo(mul_lo), .carry(carry)
);

// File: tb/ucode_alu_bench.sv
module ucode_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic [3:0]  opcode;
  logic        set_carry;
  logic [15:0] src_a, src_b;
  logic [15:0] result, mul_lo;
  logic        carry;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  bit  exp_c   = 1'b0;
  logic [15:0] exp_mlo = '0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_alu u_ucode_alu (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .set_carry(set_carry), .src_a(src_a), .src_b(src_b),
    .result(result), .mul_lo(mul_lo), .carry(carry)
  );

  function automatic string tag_of(int op);
    case (op)
      0, 1:          return "R3";
      2, 3:          return "R4";
      4, 5, 6, 7:    return "R7";
      8, 9, 10:      return "R8";
      11, 12:        return "R9";
      13:            return "R10";
      default:       return "R2";
    endcase
  endfunction

  function automatic logic [15:0] model_res(int op, longint a, longint b, longint c);
    longint n;
    longint sa;
    n  = b & 15;
    sa = (a >= 32768) ? a - 65536 : a;
    case (op)
      0:  return 16'(a + b);
      1:  return 16'(a + b + c);
      2:  return 16'(a - b);
      3:  return 16'(a - b - 1 + c);
      4:  return 16'(a | b);
      5:  return 16'(a & b);
      6:  return 16'(a ^ b);
      7:  return 16'(a & (~b));
      8:  return 16'(a >> n);
      9:  return 16'(a << n);
      10: return 16'(sa >>> n);
      11: return 16'((a << n) | (a >> (16 - n)));
      12: return 16'((a >> n) | (a << (16 - n)));
      13: return 16'((a * b) >> 16);
      default: return 16'd0;
    endcase
  endfunction

  function automatic bit model_cout(int op, longint a, longint b, longint c);
    longint s;
    case (op)
      0: s = a + b;
      1: s = a + b + c;
      2: s = a + (65535 - b) + 1;
      default: s = a + (65535 - b) + c;
    endcase
    return s[16];
  endfunction

  function automatic logic [15:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[15:0];
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run_op(int op, logic [15:0] a, logic [15:0] b, bit sc, bit en);
    exec_en   = en;
    opcode    = 4'(op);
    set_carry = sc;
    src_a     = a;
    src_b     = b;
    #1;
    check(tag_of(op), "result", longint'(result), longint'(model_res(op, a, b, exp_c)));
    if (en && sc && op <= 3) exp_c = model_cout(op, a, b, exp_c);
    if (en && op == 13) exp_mlo = 16'((longint'(a) * longint'(b)) & 16'hFFFF);
    @(posedge clk);
    @(negedge clk);
    if (op <= 3 && en && sc) check("R5", "carry", longint'(carry), longint'(exp_c));
    else                     check("R6", "carry", longint'(carry), longint'(exp_c));
    if (op == 13 && en) check("R11", "mul_lo update", longint'(mul_lo), longint'(exp_mlo));
    else                check("R11", "mul_lo hold", longint'(mul_lo), longint'(exp_mlo));
  endtask

  task automatic preset_carry(bit v);
    if (v) run_op(0, 16'hFFFF, 16'h0001, 1'b1, 1'b1);
    else   run_op(0, 16'h0000, 16'h0000, 1'b1, 1'b1);
  endtask

  initial begin
    logic [15:0] corners [5];
    corners = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001};
    rst_n = 1'b0; exec_en = 1'b0; opcode = '0; set_carry = 1'b0;
    src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "carry after reset", longint'(carry), 0);
    check("R1", "mul_lo after reset", longint'(mul_lo), 0);

    // near-exhaustive sweep over every code, carry state and qualifier
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 300; k++) begin
        logic [15:0] a, b;
        a = (k % 5 == 0) ? corners[(k / 5) % 5] : next_rand();
        b = (k % 3 == 0) ? corners[(k / 3) % 5] : next_rand();
        preset_carry(k[0]);
        run_op(op, a, b, k[1], (k % 7) != 0);
      end
    end

    // shift and rotate amounts, upper amount bits set
    for (int op = 8; op <= 12; op++) begin
      for (int b = 0; b < 64; b++) begin
        run_op(op, 16'h8421, 16'(b) | 16'hA5C0, 1'b0, 1'b1);
        run_op(op, 16'hF00F, 16'(b), 1'b1, 1'b1);
      end
    end

    // copy through OR with zero, and subtract carry edges
    run_op(4, 16'hBEEF, 16'h0000, 1'b0, 1'b1);
    preset_carry(1'b0);
    run_op(2, 16'h1234, 16'h1234, 1'b1, 1'b1);
    check("R5", "a==b sub gives no borrow", longint'(carry), 1);
    run_op(2, 16'h0000, 16'h0001, 1'b1, 1'b1);
    check("R5", "a<b sub gives borrow", longint'(carry), 0);
    run_op(13, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1);
    check("R11", "max product low", longint'(mul_lo), 1);
    run_op(13, 16'h1234, 16'h5678, 1'b0, 1'b0);
    check("R11", "disabled multiply keeps low", longint'(mul_lo), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule